// File: doc/BRIEF.md
# Circular DMA Channel Controller

This block is one DMA channel. It moves 8-bit items between a fixed peripheral data address and a memory buffer, so the processor does not have to copy each item itself. Software programs an item count, the peripheral address and the memory buffer address, then sets a control word that chooses the direction, the memory address increment, the looping mode and the interrupt enables. While the channel is enabled, each time the peripheral requests service the channel runs one read cycle and then one write cycle on a simple memory-mapped master port.

In normal mode the channel turns itself off after the last item. In circular mode it reloads the count and the memory address after the last item and keeps going with no software action. A half-way event and a completion event come from the same item counter, so software can work on one half of a buffer while the channel fills the other half. A bus error response stops the channel and records an error flag.

Top module: `dma_chan`

## Requirements
- R1: After reset the control word, the count, the status flags, `irq` and `m_req` are all zero.
- R2: The register offsets are 0 control, 1 item count, 2 peripheral address, 3 memory address and 4 status. Control bit 0 is enable, bit 1 the completion interrupt enable, bit 2 the half-way interrupt enable, bit 3 the error interrupt enable, bit 4 the direction, bit 5 circular mode and bit 7 memory increment. Bits 9:8 and 11:10 are the peripheral and memory element sizes (0 means 8-bit) and are stored as written. Bit 6 and bits 31:12 read as zero.
- R3: A write to the count, peripheral address or memory address register while enable is set has no effect.
- R4: A transfer starts only when, at the deciding clock edge, enable is set, `dreq` is high and the remaining count is nonzero. A transfer is one read cycle followed by one write cycle. A count of zero at enable time gives no bus cycles.
- R5: With direction 0 the read uses the peripheral address and the write uses the current memory address. With direction 1 the roles swap. The byte written equals the byte read.
- R6: With memory increment set, the current memory address goes up by one after each completed item. Otherwise it stays fixed. The peripheral address never changes on its own.
- R7: In normal mode, completing the last item clears enable and leaves the count at zero.
- R8: In circular mode, completing the last item reloads the count with the programmed value and the memory address with its programmed start, and transfers continue.
- R9: Status bit 0 (half) is set when floor(N/2) items of an N-item round have moved, with N at least 2. Status bit 1 (complete) is set when the count reaches zero. This repeats on every circular round.
- R10: An error response in either phase clears enable, sets status bit 2 and leaves the count unchanged. A write phase is never issued after a failed read.
- R11: Writing ones to the status register clears those flags. A flag event in the same cycle wins over the clear.
- R12: `irq` is high exactly when some status flag is set together with its interrupt enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| dreq | input | 1 | Peripheral service request, level |
| m_req | output | 1 | Master cycle request, held until ack or error |
| m_we | output | 1 | Master cycle is a write |
| m_addr | output | AW | Master address |
| m_wdata | output | DW | Master write data |
| m_ack | input | 1 | Master cycle completed |
| m_err | input | 1 | Master cycle failed |
| m_rdata | input | DW | Master read data, valid with `m_ack` |
| irq | output | 1 | Interrupt request |

## Verification
A wrong remaining count or memory cursor shows at the ports on the very next write cycle, as a wrong `m_addr`, and a wrong count also shows as a half or completion flag raised one item too early or too late. The reference model follows every bus completion and register write, and checks each read and write address, each byte carried and the `irq` level every clock. A stuck enable or a missed reload therefore appears within one transfer, either as a bus cycle that should not start or as a channel that stops too early. The circular run covers more than two rounds so that reload faults are caught.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [2:0] {
        OFS_CTRL  = 3'd0,
        OFS_COUNT = 3'd1,
        OFS_PADDR = 3'd2,
        OFS_MADDR = 3'd3,
        OFS_STAT  = 3'd4
    } reg_ofs_e;

    // control word, bit 0 at the bottom
    typedef struct packed {
        logic [1:0] msize;
        logic [1:0] psize;
        logic       minc;
        logic       rsvd;
        logic       circ;
        logic       dir;
        logic       teie;
        logic       htie;
        logic       tcie;
        logic       en;
    } ctrl_t;

    localparam logic [11:0] CTRL_MASK = 12'hFBF;

    typedef struct packed {
        logic err;
        logic done;
        logic half;
    } flags_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RD   = 2'd1,
        PH_WR   = 2'd2
    } phase_e;

    // true when "left" items remain exactly at the half-way mark of "total"
    function automatic logic at_half(input int unsigned total, input int unsigned left);
        return ((total / 2) != 0) && (left == total - (total / 2));
    endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic [CW-1:0] cnt,
    input  logic [AW-1:0] mcur,
    input  logic          ev_half,
    input  logic          ev_done,
    input  logic          ev_err,
    output ctrl_t         ctrl,
    output logic [AW-1:0] paddr,
    output flags_t        flags,
    output logic          ld_cnt,
    output logic          ld_mem,
    output logic          irq
);

    ctrl_t  ctrl_d;
    flags_t set_v, clr_v;
    logic   hw_stop;
    logic   wr_ctrl, wr_pad, wr_stat;

    assign wr_ctrl = reg_we && (reg_addr == OFS_CTRL);
    assign wr_pad  = reg_we && (reg_addr == OFS_PADDR) && !ctrl.en;
    assign wr_stat = reg_we && (reg_addr == OFS_STAT);
    assign ld_cnt  = reg_we && (reg_addr == OFS_COUNT) && !ctrl.en;
    assign ld_mem  = reg_we && (reg_addr == OFS_MADDR) && !ctrl.en;

    assign hw_stop = ev_err || (ev_done && !ctrl.circ);

    always_comb begin
        ctrl_d = ctrl;
        if (wr_ctrl) begin
            ctrl_d = ctrl_t'(reg_wdata[11:0] & CTRL_MASK);
        end
        if (hw_stop) begin
            ctrl_d.en = 1'b0;
        end
    end

    always_comb begin
        set_v = '{err: ev_err, done: ev_done, half: ev_half};
        clr_v = wr_stat ? flags_t'(reg_wdata[2:0]) : flags_t'(3'b000);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            paddr <= '0;
            flags <= '0;
        end else begin
            ctrl  <= ctrl_d;
            flags <= (flags & ~clr_v) | set_v;
            if (wr_pad) begin
                paddr <= reg_wdata[AW-1:0];
            end
        end
    end

    always_comb begin
        case (reg_addr)
            OFS_CTRL:  reg_rdata = {20'd0, ctrl};
            OFS_COUNT: reg_rdata = 32'(cnt);
            OFS_PADDR: reg_rdata = 32'(paddr);
            OFS_MADDR: reg_rdata = 32'(mcur);
            OFS_STAT:  reg_rdata = {29'd0, flags};
            default:   reg_rdata = '0;
        endcase
    end

    assign irq = (flags.half && ctrl.htie) || (flags.done && ctrl.tcie) ||
                 (flags.err && ctrl.teie);

endmodule

// File: rtl/dma_chan_cursor.sv
module dma_chan_cursor
    import dma_chan_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_cnt,
    input  logic          ld_mem,
    input  logic [31:0]   wdata,
    input  logic          xfer_done,
    input  logic          circ,
    input  logic          minc,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] orig,
    output logic [AW-1:0] mcur,
    output logic          ev_half,
    output logic          ev_done
);

    logic [AW-1:0] mbase;
    logic [CW-1:0] cnt_nx;

    assign cnt_nx  = cnt - CW'(1);
    assign ev_done = xfer_done && (cnt_nx == '0);
    assign ev_half = xfer_done && at_half(32'(orig), 32'(cnt_nx));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            orig  <= '0;
            mcur  <= '0;
            mbase <= '0;
        end else begin
            if (ld_cnt) begin
                cnt  <= wdata[CW-1:0];
                orig <= wdata[CW-1:0];
            end else if (xfer_done) begin
                cnt <= (ev_done && circ) ? orig : cnt_nx;
            end

            if (ld_mem) begin
                mcur  <= wdata[AW-1:0];
                mbase <= wdata[AW-1:0];
            end else if (xfer_done) begin
                if (ev_done && circ) begin
                    mcur <= mbase;
                end else if (minc) begin
                    mcur <= mcur + AW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dma_chan_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          dir,
    input  logic          have_work,
    input  logic          dreq,
    input  logic [AW-1:0] paddr,
    input  logic [AW-1:0] mcur,
    output logic          m_req,
    output logic          m_we,
    output logic [AW-1:0] m_addr,
    output logic [DW-1:0] m_wdata,
    input  logic          m_ack,
    input  logic          m_err,
    input  logic [DW-1:0] m_rdata,
    output logic          xfer_done,
    output logic          xfer_err
);

    phase_e        ph;
    logic [DW-1:0] hold;
    logic [AW-1:0] src, dst;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= PH_IDLE;
            hold <= '0;
        end else begin
            unique case (ph)
                PH_IDLE: if (en && dreq && have_work) ph <= PH_RD;
                PH_RD: begin
                    if (m_err) begin
                        ph <= PH_IDLE;
                    end else if (m_ack) begin
                        hold <= m_rdata;
                        ph   <= PH_WR;
                    end
                end
                PH_WR: if (m_err || m_ack) ph <= PH_IDLE;
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign src       = dir ? mcur : paddr;
    assign dst       = dir ? paddr : mcur;
    assign m_req     = (ph != PH_IDLE);
    assign m_we      = (ph == PH_WR);
    assign m_addr    = m_we ? dst : src;
    assign m_wdata   = hold;
    assign xfer_done = (ph == PH_WR) && m_ack && !m_err;
    assign xfer_err  = m_req && m_err;

endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dma_chan_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 8,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          dreq,
    output logic          m_req,
    output logic          m_we,
    output logic [AW-1:0] m_addr,
    output logic [DW-1:0] m_wdata,
    input  logic          m_ack,
    input  logic          m_err,
    input  logic [DW-1:0] m_rdata,
    output logic          irq
);

    ctrl_t         ctrl_q;
    flags_t        flags_q;
    logic [AW-1:0] paddr_q, mcur_q;
    logic [CW-1:0] cnt_q, orig_q;
    logic          ld_cnt, ld_mem;
    logic          ev_half, ev_done, xfer_done, xfer_err;

    dma_chan_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cnt       (cnt_q),
        .mcur      (mcur_q),
        .ev_half   (ev_half),
        .ev_done   (ev_done),
        .ev_err    (xfer_err),
        .ctrl      (ctrl_q),
        .paddr     (paddr_q),
        .flags     (flags_q),
        .ld_cnt    (ld_cnt),
        .ld_mem    (ld_mem),
        .irq       (irq)
    );

    dma_chan_cursor #(.AW(AW), .CW(CW)) u_cursor (
        .clk       (clk),
        .rst       (rst),
        .ld_cnt    (ld_cnt),
        .ld_mem    (ld_mem),
        .wdata     (reg_wdata),
        .xfer_done (xfer_done),
        .circ      (ctrl_q.circ),
        .minc      (ctrl_q.minc),
        .cnt       (cnt_q),
        .orig      (orig_q),
        .mcur      (mcur_q),
        .ev_half   (ev_half),
        .ev_done   (ev_done)
    );

    dma_chan_engine #(.AW(AW), .DW(DW)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .en        (ctrl_q.en),
        .dir       (ctrl_q.dir),
        .have_work (cnt_q != '0),
        .dreq      (dreq),
        .paddr     (paddr_q),
        .mcur      (mcur_q),
        .m_req     (m_req),
        .m_we      (m_we),
        .m_addr    (m_addr),
        .m_wdata   (m_wdata),
        .m_ack     (m_ack),
        .m_err     (m_err),
        .m_rdata   (m_rdata),
        .xfer_done (xfer_done),
        .xfer_err  (xfer_err)
    );

endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk
    import dma_chan_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_we,
    input logic [2:0]    reg_addr,
    input logic          dreq,
    input logic          m_req,
    input logic          m_we,
    input logic          m_ack,
    input logic          m_err,
    input ctrl_t         ctrl,
    input flags_t        flags,
    input logic [AW-1:0] paddr,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] orig
);

    // R4: every transfer opens with a read cycle
    p_first_read_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(m_req) |-> !m_we);

    // R4: a cycle only starts from an enabled channel with work and a request
    p_start_legal_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(m_req) |-> $past(ctrl.en && dreq && (cnt != '0)));

    // R3: count programming is locked while enabled
    p_count_lock_r3: assert property (@(posedge clk) disable iff (rst)
        (ctrl.en && reg_we && (reg_addr == 3'd1)) |=> $stable(orig));

    // R6: peripheral address never moves while enabled
    p_paddr_fixed_r6: assert property (@(posedge clk) disable iff (rst)
        ctrl.en |=> $stable(paddr));

    // R7: last item in normal mode stops the channel
    p_normal_stop_r7: assert property (@(posedge clk) disable iff (rst)
        (m_req && m_we && m_ack && !m_err && (cnt == CW'(1)) && !ctrl.circ)
        |=> (!ctrl.en && (cnt == '0)));

    // R8: last item in circular mode reloads the count
    p_circ_reload_r8: assert property (@(posedge clk) disable iff (rst)
        (m_req && m_we && m_ack && !m_err && (cnt == CW'(1)) && ctrl.circ && ctrl.en)
        |=> (cnt == $past(orig)));

    // R10: an error response stops the channel and records the error
    p_err_stop_r10: assert property (@(posedge clk) disable iff (rst)
        (m_req && m_err) |=> (!ctrl.en && flags.err));

    // R10: a failed read is never followed by a write phase
    p_no_wr_after_err_r10: assert property (@(posedge clk) disable iff (rst)
        (m_req && !m_we && m_err) |=> !m_req);

endmodule

bind dma_chan dma_chan_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .dreq     (dreq),
    .m_req    (m_req),
    .m_we     (m_we),
    .m_ack    (m_ack),
    .m_err    (m_err),
    .ctrl     (ctrl_q),
    .flags    (flags_q),
    .paddr    (paddr_q),
    .cnt      (cnt_q),
    .orig     (orig_q)
);

// File: tb/dma_chan_tb.sv
module dma_chan_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 8;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          dreq = 1'b0;
    logic          m_req, m_we;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_wdata;
    logic          m_ack, m_err;
    logic [DW-1:0] m_rdata;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma_chan #(.AW(AW), .DW(DW), .CW(CW)) u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_ack(m_ack), .m_err(m_err), .m_rdata(m_rdata), .irq(irq)
    );

    // ---------------- bus responder ----------------
    logic [7:0] mem [0:255];
    logic [7:0] periph_next;
    bit         err_armed = 0;
    logic [7:0] err_addr = '0;
    logic [7:0] periph_log [$];

    always @(posedge clk) begin
        if (rst) begin
            m_ack       <= 1'b0;
            m_err       <= 1'b0;
            m_rdata     <= '0;
            periph_next <= 8'd1;
        end else begin
            m_ack <= 1'b0;
            m_err <= 1'b0;
            if (m_req && !m_ack && !m_err) begin
                if (err_armed && m_addr[7:0] == err_addr) begin
                    m_err <= 1'b1;
                end else begin
                    m_ack <= 1'b1;
                    if (m_we) begin
                        mem[m_addr[7:0]] <= m_wdata;
                        if (m_addr[7:0] == 8'hE0) periph_log.push_back(m_wdata);
                    end else if (m_addr[7:0] == 8'hF0) begin
                        m_rdata     <= periph_next;
                        periph_next <= periph_next + 8'd1;
                    end else begin
                        m_rdata <= mem[m_addr[7:0]];
                    end
                end
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int unsigned md_ctrl = 0, md_cnt = 0, md_orig = 0;
    int unsigned md_pad = 0, md_mbase = 0, md_mcur = 0;
    bit md_ht = 0, md_tc = 0, md_te = 0;
    bit start_ok = 0, req_prev = 0;
    logic [7:0] rd_byte = '0;
    int wr_seen = 0, starts = 0;

    always @(negedge clk) begin
        if (rst) begin
            md_ctrl = 0; md_cnt = 0; md_orig = 0; md_pad = 0;
            md_mbase = 0; md_mcur = 0; md_ht = 0; md_tc = 0; md_te = 0;
            start_ok = 0; req_prev = 0;
        end else if (!finished) begin
            bit old_en, old_dir, old_circ, old_minc, ht_ev, tc_ev, err_ev;
            bit exp_irq;
            int unsigned nxt;
            old_en   = md_ctrl[0];
            old_dir  = md_ctrl[4];
            old_circ = md_ctrl[5];
            old_minc = md_ctrl[7];
            // R12: interrupt level every cycle
            exp_irq = (md_ht && md_ctrl[2]) || (md_tc && md_ctrl[1]) || (md_te && md_ctrl[3]);
            check("R12 irq level", {31'd0, irq}, {31'd0, exp_irq});
            // R4: new bus activity must have been allowed
            if (m_req && !req_prev) begin
                starts++;
                check("R4 start allowed", {31'd0, start_ok}, 32'd1);
                check("R4 first phase is read", {31'd0, m_we}, 32'd0);
            end
            req_prev = m_req;
            ht_ev = 0; tc_ev = 0;
            err_ev = m_req && m_err;
            if (m_req && !m_we && m_ack && !m_err) begin
                check("R5 read address", m_addr, old_dir ? md_mcur : md_pad);
                rd_byte = m_rdata;
            end
            if (m_req && m_we && m_ack && !m_err) begin
                wr_seen++;
                check("R5 write address", m_addr, old_dir ? md_pad : md_mcur);
                check("R5 byte carried", {24'd0, m_wdata}, {24'd0, rd_byte});
                nxt   = md_cnt - 1;
                ht_ev = (md_orig / 2 != 0) && (nxt == md_orig - md_orig / 2);
                tc_ev = (nxt == 0);
                if (tc_ev && old_circ) begin
                    md_cnt  = md_orig;
                    md_mcur = md_mbase;
                end else begin
                    md_cnt = nxt;
                    if (old_minc) md_mcur = md_mcur + 1;
                end
            end
            if (reg_we) begin
                case (reg_addr)
                    3'd0: md_ctrl = reg_wdata & 32'hFBF;
                    3'd1: if (!old_en) begin md_cnt = reg_wdata & 32'hFFFF; md_orig = md_cnt; end
                    3'd2: if (!old_en) md_pad = reg_wdata;
                    3'd3: if (!old_en) begin md_mbase = reg_wdata; md_mcur = reg_wdata; end
                    3'd4: begin
                        if (reg_wdata[0]) md_ht = 0;
                        if (reg_wdata[1]) md_tc = 0;
                        if (reg_wdata[2]) md_te = 0;
                    end
                    default: ;
                endcase
            end
            if (ht_ev) md_ht = 1;
            if (tc_ev) md_tc = 1;
            if (err_ev) md_te = 1;
            if (err_ev || (tc_ev && !old_circ)) md_ctrl = md_ctrl & ~32'd1;
            start_ok = md_ctrl[0] && (md_cnt != 0) && dreq;
        end
    end

    // ---------------- register access ----------------
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a;
        #2 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic wait_writes(input int n);
        for (int i = 0; i < 2000 && wr_seen < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] v;
        int base;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        mem[8'h20] = 8'hA0; mem[8'h21] = 8'hA1; mem[8'h22] = 8'hA2;
        idle(5);
        rst = 1'b0;
        idle(2);

        // R1 reset state
        rd(3'd0, v); check("R1 ctrl after reset", v, 32'd0);
        rd(3'd1, v); check("R1 count after reset", v, 32'd0);
        rd(3'd4, v); check("R1 status after reset", v, 32'd0);
        check("R1 irq after reset", {31'd0, irq}, 32'd0);
        check("R1 m_req after reset", {31'd0, m_req}, 32'd0);

        // R2 control field storage
        wr(3'd0, 32'hFFFF_FFFE);
        rd(3'd0, v); check("R2 ctrl readback mask", v, 32'h0000_0FBE);
        wr(3'd0, 32'd0);

        // normal, periph->mem, increment, 4 items
        wr(3'd1, 32'd4);
        wr(3'd2, 32'h0000_00F0);
        wr(3'd3, 32'h0000_0010);
        rd(3'd2, v); check("R2 paddr readback", v, 32'h0000_00F0);
        wr(3'd0, 32'h0000_0087);
        idle(20);
        check("R4 no request without dreq", starts, 0);
        wr(3'd1, 32'd9);
        rd(3'd1, v); check("R3 count locked", v, 32'd4);
        wr(3'd3, 32'h0000_0055);
        rd(3'd3, v); check("R3 maddr locked", v, 32'h0000_0010);
        wr(3'd2, 32'h0000_0077);
        rd(3'd2, v); check("R3 paddr locked", v, 32'h0000_00F0);
        base = wr_seen;
        dreq = 1'b1;
        wait_writes(base + 4);
        idle(10);
        dreq = 1'b0;
        check("R7 exactly four items", wr_seen - base, 4);
        for (int i = 0; i < 4; i++)
            check("R5 buffer filled from peripheral", {24'd0, mem[8'h10 + i]}, i + 1);
        rd(3'd1, v); check("R7 count left at zero", v, 32'd0);
        rd(3'd0, v); check("R7 enable cleared", v & 32'd1, 32'd0);
        rd(3'd3, v); check("R6 memory cursor advanced", v, 32'h0000_0014);
        rd(3'd4, v); check("R9 half and complete set", v, 32'd3);
        check("R12 irq raised", {31'd0, irq}, 32'd1);

        // R11 write-one-to-clear
        wr(3'd4, 32'd2);
        rd(3'd4, v); check("R11 only complete cleared", v, 32'd1);
        check("R12 irq held by half flag", {31'd0, irq}, 32'd1);
        wr(3'd4, 32'd7);
        rd(3'd4, v); check("R11 all cleared", v, 32'd0);
        check("R12 irq dropped", {31'd0, irq}, 32'd0);

        // circular, mem->periph, increment, 3 items
        wr(3'd0, 32'd0);
        wr(3'd1, 32'd3);
        wr(3'd2, 32'h0000_00E0);
        wr(3'd3, 32'h0000_0020);
        periph_log.delete();
        wr(3'd0, 32'h0000_00B7);
        dreq = 1'b1;
        for (int i = 0; i < 4000 && periph_log.size() < 7; i++) @(posedge clk);
        #1 dreq = 1'b0;
        idle(10);
        check("R8 seven items delivered", periph_log.size() >= 7, 1);
        for (int i = 0; i < 7 && i < periph_log.size(); i++)
            check("R8 circular replay order", {24'd0, periph_log[i]}, 32'hA0 + (i % 3));
        rd(3'd0, v); check("R8 still enabled", v & 32'd1, 32'd1);
        rd(3'd1, v); check("R8 count consistent", v, md_cnt);
        rd(3'd4, v); check("R9 flags in circular", v & 32'd3, 32'd3);
        wr(3'd0, 32'd0);
        wr(3'd4, 32'd7);

        // R4 zero count gives no cycles
        wr(3'd1, 32'd0);
        base = starts;
        dreq = 1'b1;
        wr(3'd0, 32'h0000_0081);
        idle(20);
        dreq = 1'b0;
        check("R4 zero count no transfer", starts - base, 0);
        wr(3'd0, 32'd0);

        // R6 fixed memory address, interrupts masked
        wr(3'd1, 32'd2);
        wr(3'd2, 32'h0000_00F0);
        wr(3'd3, 32'h0000_0030);
        base = wr_seen;
        wr(3'd0, 32'h0000_0001);
        dreq = 1'b1;
        wait_writes(base + 2);
        idle(10);
        dreq = 1'b0;
        rd(3'd3, v); check("R6 memory address held", v, 32'h0000_0030);
        check("R6 last byte wins", {24'd0, mem[8'h30]}, 32'd6);
        rd(3'd4, v); check("R9 complete flag set", v & 32'd2, 32'd2);
        check("R12 masked flags keep irq low", {31'd0, irq}, 32'd0);
        wr(3'd4, 32'd7);

        // R10 error on second write
        wr(3'd1, 32'd4);
        wr(3'd3, 32'h0000_0040);
        err_addr = 8'h41;
        err_armed = 1;
        base = wr_seen;
        wr(3'd0, 32'h0000_0089);
        dreq = 1'b1;
        idle(40);
        dreq = 1'b0;
        err_armed = 0;
        check("R10 one item before error", wr_seen - base, 1);
        rd(3'd0, v); check("R10 enable cleared", v & 32'd1, 32'd0);
        rd(3'd1, v); check("R10 count unchanged by error", v, 32'd3);
        rd(3'd4, v); check("R10 error flag", v, 32'd4);
        check("R10 failed write not stored", {24'd0, mem[8'h41]}, 32'd0);
        check("R12 error irq", {31'd0, irq}, 32'd1);
        wr(3'd4, 32'd4);
        idle(3);
        check("R11 error cleared irq", {31'd0, irq}, 32'd0);

        finish_run();
    end

endmodule